// File: doc/BRIEF.md
# Bus Hold, Lock and Page-Hit Controller

This block sits at the edge of a processor's external memory bus. It decides when the processor hands the bus to another master. It keeps the bus request line in step with pending memory requests. It presents the bus lock line in step with the address strobes of the cycles being issued. It also signals when the word address of a newly issued cycle lies in the same DRAM page as the address of the cycle before it.

The hold request arrives asynchronously and goes through a synchronizer. The block grants the bus only when no issued cycle is still waiting for completion and the bus is not locked. While the bus is granted, the output drivers float. The bus lock follows a software lock bit. The bit is captured when a request is issued, and the lock line changes only when that request's address strobe appears. The DRAM page size is chosen at run time by a 3-bit code.

Top module: `bus_hold_lock_ctrl`

## Requirements
- R1: When the bus is idle and unlocked, `holdAck` rises at the third rising clock edge after `holdReq` goes high. It never rises in a cycle in which `holdReq` has not been seen through the synchronizer.
- R2: `floatEn` is high in exactly the cycles in which `holdAck` is high.
- R3: Once raised, `holdAck` stays high while `holdReq` stays high. It falls at the third rising edge after `holdReq` goes low. A `cycleStart` in the first cycle with `holdAck` low is accepted and issues a cycle.
- R4: Hold requests are acknowledged with the same timing while `rst` is high.
- R5: `busReq` equals `reqPending` in every cycle, including cycles in which `holdAck` is high.
- R6: `holdAck` does not rise while the bus lock is asserted, whatever `holdReq` does.
- R7: The lock bit used for a cycle is the value `lockBit` had at the most recent `reqIssue` pulse. If `reqIssue` and `cycleStart` come in the same cycle, the current value of `lockBit` is used. `lockOut` takes that value in the same cycle as `cycleStart`, even if `lockBit` has changed since the pulse.
- R8: `lockOut` changes only in cycles with an accepted `cycleStart`. After the lock bit is cleared, it falls with the strobe of the next issued cycle and holds its value in between.
- R9: `nearOut` is high during an accepted `cycleStart` when `cycleAddr` matches the address of the previous issued cycle on all bits from bit 9+`pageSel` upward. Here `pageSel`=N selects a page of 2^(9+N) words. Lower address bits are ignored.
- R10: `nearOut` is low on the first issued cycle after reset and on the first issued cycle after `holdAck` has been high.
- R11: `holdAck` rises no earlier than the edge after the `cycleDone` that completes the last outstanding issued cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| holdReq | input | 1 | Asynchronous bus hold request from another master |
| reqPending | input | 1 | Internal memory request is waiting |
| reqIssue | input | 1 | Pulse: a new request is generated internally (lock bit sampled) |
| cycleStart | input | 1 | Address strobe of a bus cycle being issued this clock |
| cycleDone | input | 1 | Pulse: one outstanding bus cycle completes |
| lockBit | input | 1 | Software lock control bit |
| pageSel | input | 3 | DRAM page size code N, page = 2^(9+N) words |
| cycleAddr | input | ADDR_W (29) | 64-bit word address of the cycle being issued |
| holdAck | output | 1 | Bus hold acknowledge |
| busReq | output | 1 | Bus request |
| lockOut | output | 1 | Bus lock |
| floatEn | output | 1 | Float the bus outputs |
| nearOut | output | 1 | Current cycle is in the same DRAM page as the previous one |

## Verification
The bench uses the defaults: a 29-bit word address, a two-stage synchronizer and up to three outstanding cycles. With a 29-bit address, page codes 0, 3 and 7 put the compare boundary at bits 9, 12 and 16. Addresses just inside and just past each boundary are issued. With three outstanding cycles allowed, a grant can be held back by one pending completion and then released exactly one edge after it. With the short synchronizer, every acknowledge edge falls at an exact, checkable clock.

// File: rtl/bhl_pkg.sv
package bhl_pkg;
  localparam int PAGE_BASE_LOG = 9;
  localparam int PAGE_SEL_W = 3;

  typedef struct packed {
    logic capturePage;
    logic dropPage;
  } bhlStrobe_t;
endpackage

// File: rtl/bhl_sync.sv
module bhl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/bhl_ctrl.sv
module bhl_ctrl
  import bhl_pkg::*;
#(
  parameter int MAX_OUT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       holdSync,
  input  logic       cycleStart,
  input  logic       cycleDone,
  input  logic       reqIssue,
  input  logic       lockBit,
  output logic       holdAck,
  output logic       lockOut,
  output bhlStrobe_t strobes
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [CNT_W-1:0] outCnt;
  logic lockTag;
  logic lockReg;
  logic ackNext;
  logic startOk;
  logic newLock;
  logic doneOk;

  assign startOk = cycleStart && !holdAck;
  assign doneOk  = cycleDone && (outCnt != '0);
  assign newLock = reqIssue ? lockBit : lockTag;

  always_ff @(posedge clk) begin
    if (rst) begin
      outCnt  <= '0;
      lockTag <= 1'b0;
      lockReg <= 1'b0;
    end else begin
      case ({startOk, doneOk})
        2'b10:   outCnt <= outCnt + 1'b1;
        2'b01:   outCnt <= outCnt - 1'b1;
        default: outCnt <= outCnt;
      endcase
      if (reqIssue) lockTag <= lockBit;
      if (startOk)  lockReg <= newLock;
    end
  end

  always_comb begin
    if (rst)          ackNext = holdSync;
    else if (holdAck) ackNext = holdSync;
    else              ackNext = holdSync && (outCnt == '0) && !lockReg && !cycleStart;
  end

  always_ff @(posedge clk) begin
    holdAck <= ackNext;
  end

  assign lockOut = startOk ? newLock : lockReg;

  always_comb begin
    strobes.capturePage = startOk;
    strobes.dropPage    = holdAck;
  end
endmodule

// File: rtl/bhl_datapath.sv
module bhl_datapath
  import bhl_pkg::*;
#(
  parameter int ADDR_W = 29
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bhlStrobe_t            strobes,
  input  logic [PAGE_SEL_W-1:0] pageSel,
  input  logic [ADDR_W-1:0]     cycleAddr,
  output logic                  nearOut
);
  logic [ADDR_W-1:0] prevAddr;
  logic prevValid;
  logic [ADDR_W-1:0] diffBit;
  int unsigned boundary;

  assign boundary = PAGE_BASE_LOG + 32'(pageSel);

  always_ff @(posedge clk) begin
    if (rst || strobes.dropPage) begin
      prevValid <= 1'b0;
    end else if (strobes.capturePage) begin
      prevValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.capturePage) prevAddr <= cycleAddr;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    assign diffBit[i] = (i >= boundary) && (cycleAddr[i] != prevAddr[i]);
  end

  assign nearOut = strobes.capturePage && prevValid && !(|diffBit);
endmodule

// File: rtl/bus_hold_lock_ctrl.sv
module bus_hold_lock_ctrl
  import bhl_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_OUT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              holdReq,
  input  logic              reqPending,
  input  logic              reqIssue,
  input  logic              cycleStart,
  input  logic              cycleDone,
  input  logic              lockBit,
  input  logic [2:0]        pageSel,
  input  logic [ADDR_W-1:0] cycleAddr,
  output logic              holdAck,
  output logic              busReq,
  output logic              lockOut,
  output logic              floatEn,
  output logic              nearOut
);
  logic holdSync;
  bhlStrobe_t strobes;

  bhl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .asyncIn(holdReq), .syncOut(holdSync)
  );

  bhl_ctrl #(.MAX_OUT(MAX_OUT)) u_ctrl (
    .clk(clk), .rst(rst), .holdSync(holdSync), .cycleStart(cycleStart),
    .cycleDone(cycleDone), .reqIssue(reqIssue), .lockBit(lockBit),
    .holdAck(holdAck), .lockOut(lockOut), .strobes(strobes)
  );

  bhl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .pageSel(pageSel),
    .cycleAddr(cycleAddr), .nearOut(nearOut)
  );

  assign busReq  = reqPending;
  assign floatEn = holdAck;
endmodule

// File: rtl/bhl_checker.sv
module bhl_checker (
  input logic clk,
  input logic rst,
  input logic holdSync,
  input logic holdAck,
  input logic cycleStart,
  input logic cycleDone,
  input logic lockOut,
  input logic nearOut,
  input logic reqPending,
  input logic busReq
);
  logic [7:0] chkCnt;
  logic freshPage;

  always_ff @(posedge clk) begin
    if (rst) begin
      chkCnt    <= '0;
      freshPage <= 1'b1;
    end else begin
      if (cycleStart && !holdAck && !(cycleDone && chkCnt != 0)) chkCnt <= chkCnt + 1'b1;
      else if (!(cycleStart && !holdAck) && cycleDone && chkCnt != 0) chkCnt <= chkCnt - 1'b1;
      if (holdAck) freshPage <= 1'b1;
      else if (cycleStart) freshPage <= 1'b0;
    end
  end

  p_ack_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (holdAck && holdSync) |=> holdAck);

  p_no_ack_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (!holdAck && lockOut) |=> !holdAck);

  p_lock_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !cycleStart |-> $stable(lockOut));

  p_fresh_no_near_r10: assert property (@(posedge clk) disable iff (rst)
    (cycleStart && freshPage) |-> !nearOut);

  p_ack_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(holdAck) |-> $past(chkCnt == 0 && !cycleStart));

  p_busreq_r5: assert property (@(posedge clk) disable iff (rst)
    (holdAck && reqPending) |-> busReq);
endmodule

bind bus_hold_lock_ctrl bhl_checker u_chk (
  .clk(clk), .rst(rst), .holdSync(holdSync), .holdAck(holdAck),
  .cycleStart(cycleStart), .cycleDone(cycleDone), .lockOut(lockOut),
  .nearOut(nearOut), .reqPending(reqPending), .busReq(busReq)
);

// File: tb/bus_hold_lock_ctrl_test.sv
`timescale 1ns/1ps
module bus_hold_lock_ctrl_test;
  logic clk = 1'b0;
  logic rst, holdReq, reqPending, reqIssue, cycleStart, cycleDone, lockBit;
  logic [2:0] pageSel;
  logic [28:0] cycleAddr;
  logic holdAck, busReq, lockOut, floatEn, nearOut;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_hold_lock_ctrl uut (
    .clk(clk), .rst(rst), .holdReq(holdReq), .reqPending(reqPending),
    .reqIssue(reqIssue), .cycleStart(cycleStart), .cycleDone(cycleDone),
    .lockBit(lockBit), .pageSel(pageSel), .cycleAddr(cycleAddr),
    .holdAck(holdAck), .busReq(busReq), .lockOut(lockOut),
    .floatEn(floatEn), .nearOut(nearOut)
  );

  task automatic chk(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic issue(logic [28:0] addr, output logic nearSeen, output logic lockSeen);
    cycleStart = 1'b1;
    cycleAddr = addr;
    #1;
    nearSeen = nearOut;
    lockSeen = lockOut;
    tick();
    cycleStart = 1'b0;
  endtask

  task automatic finishCycle();
    cycleDone = 1'b1;
    tick();
    cycleDone = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick();
  endtask

  task automatic testResetState();
    #1;
    chk("R2 reset floatEn", floatEn, 1'b0);
    chk("R1 reset holdAck", holdAck, 1'b0);
    chk("R8 reset lockOut", lockOut, 1'b0);
  endtask

  task automatic testHoldIdle();
    holdReq = 1'b1;
    tick(2);
    chk("R1 ack not early", holdAck, 1'b0);
    tick();
    chk("R1 ack at third edge", holdAck, 1'b1);
    chk("R2 float with ack", floatEn, 1'b1);
    tick(4);
    chk("R3 ack held", holdAck, 1'b1);
    holdReq = 1'b0;
    tick(2);
    chk("R3 ack still high", holdAck, 1'b1);
    tick();
    chk("R3 ack falls", holdAck, 1'b0);
    chk("R2 float drops", floatEn, 1'b0);
  endtask

  task automatic testBusReq();
    reqPending = 1'b1;
    #1 chk("R5 busReq idle", busReq, 1'b1);
    holdReq = 1'b1;
    tick(3);
    chk("R5 busReq during hold", busReq, 1'b1);
    reqPending = 1'b0;
    #1 chk("R5 busReq low", busReq, 1'b0);
    holdReq = 1'b0;
    tick(3);
  endtask

  task automatic testHoldInReset();
    logic n, l;
    rst = 1'b1;
    holdReq = 1'b1;
    tick(3);
    chk("R4 ack in reset", holdAck, 1'b1);
    holdReq = 1'b0;
    tick(3);
    chk("R4 release in reset", holdAck, 1'b0);
    rst = 1'b0;
    tick();
    pageSel = 3'd0;
    issue(29'h1000, n, l);
    chk("R10 no near after reset", n, 1'b0);
    finishCycle();
  endtask

  task automatic testOutstanding();
    logic n, l;
    issue(29'h2000, n, l);
    holdReq = 1'b1;
    tick(5);
    chk("R11 ack waits for completion", holdAck, 1'b0);
    finishCycle();
    chk("R11 ack not on completion edge", holdAck, 1'b0);
    tick();
    chk("R11 ack after completion", holdAck, 1'b1);
    holdReq = 1'b0;
    tick(3);
    chk("R3 ack dropped", holdAck, 1'b0);
  endtask

  task automatic testAfterHold();
    logic n, l;
    pageSel = 3'd0;
    issue(29'h3000, n, l);
    finishCycle();
    holdReq = 1'b1;
    tick(4);
    holdReq = 1'b0;
    tick(2);
    chk("R3 ack high before drop", holdAck, 1'b1);
    tick();
    issue(29'h3001, n, l);
    chk("R10 no near after hold", n, 1'b0);
    chk("R3 cycle accepted on release", uut.holdAck, 1'b0);
    issue(29'h3002, n, l);
    chk("R9 near once valid again", n, 1'b1);
    finishCycle();
    finishCycle();
  endtask

  task automatic testLock();
    logic n, l;
    lockBit = 1'b1;
    reqIssue = 1'b1;
    tick();
    reqIssue = 1'b0;
    lockBit = 1'b0;
    #1 chk("R8 lock not before strobe", lockOut, 1'b0);
    tick();
    issue(29'h4000, n, l);
    chk("R7 lock with strobe", l, 1'b1);
    #1 chk("R8 lock held", lockOut, 1'b1);
    finishCycle();
    holdReq = 1'b1;
    tick(6);
    chk("R6 no ack while locked", holdAck, 1'b0);
    lockBit = 1'b0;
    reqIssue = 1'b1;
    tick();
    reqIssue = 1'b0;
    lockBit = 1'b1;
    #1 chk("R8 lock until strobe", lockOut, 1'b1);
    issue(29'h4008, n, l);
    chk("R8 unlock with strobe", l, 1'b0);
    chk("R6 still no ack", holdAck, 1'b0);
    finishCycle();
    tick();
    chk("R6 ack once unlocked", holdAck, 1'b1);
    holdReq = 1'b0;
    tick(3);
    lockBit = 1'b1;
    reqIssue = 1'b1;
    issue(29'h4010, n, l);
    reqIssue = 1'b0;
    chk("R7 same-cycle issue uses bit", l, 1'b1);
    finishCycle();
    lockBit = 1'b0;
    reqIssue = 1'b1;
    issue(29'h4018, n, l);
    reqIssue = 1'b0;
    chk("R8 same-cycle unlock", l, 1'b0);
    finishCycle();
  endtask

  task automatic testPages();
    logic n, l;
    pageSel = 3'd0;
    issue(29'h1000, n, l);
    issue(29'h11FF, n, l);
    chk("R9 N=0 same page", n, 1'b1);
    issue(29'h1200, n, l);
    chk("R9 N=0 next page", n, 1'b0);
    pageSel = 3'd7;
    issue(29'h0FFFF, n, l);
    chk("R9 N=7 same page", n, 1'b1);
    issue(29'h10000, n, l);
    chk("R9 N=7 crossing", n, 1'b0);
    pageSel = 3'd3;
    issue(29'h10FFF, n, l);
    chk("R9 N=3 same page", n, 1'b1);
    issue(29'h11000, n, l);
    chk("R9 N=3 crossing", n, 1'b0);
    issue(29'h1000_0000 | 29'h11000, n, l);
    chk("R9 top bit differs", n, 1'b0);
    for (int i = 0; i < 8; i++) finishCycle();
  endtask

  initial begin
    rst = 1'b1; holdReq = 1'b0; reqPending = 1'b0; reqIssue = 1'b0;
    cycleStart = 1'b0; cycleDone = 1'b0; lockBit = 1'b0;
    pageSel = 3'd0; cycleAddr = '0;
    @(negedge clk);
    doReset();
    testResetState();
    testHoldIdle();
    testBusReq();
    testHoldInReset();
    testOutstanding();
    testAfterHold();
    doReset();
    testLock();
    doReset();
    testPages();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule